// File: doc/BRIEF.md
# Stream-to-Memory Write Adapter

This block sits between a processing function that produces a flow-controlled stream of result words and one bank of on-board memory. Software programs where the results should land (a start address) and how many words to expect (a length) through a small register file that answers at a configurable base address, for example 0x5200. Each stream word the block accepts becomes one write on a request/acknowledge memory port. The write address starts at the programmed start and advances by one per acknowledged write.

There is no start bit. Writing the length register arms the adapter, clears its word counter and loads the start address. A readable word counter and a done flag let software see that every expected word is in memory before it moves the data to the host. Stream backpressure comes from the memory handshake. The adapter refuses words while a write waits for its acknowledge, while it is idle, and once the programmed length is reached. A length written during a transfer is held as pending and takes effect when the running transfer completes.

Top module: `s2m_write_adapter`

## Requirements
- R1: After reset `s_ready` and `mem_req` are low, and all four registers read as zero.
- R2: The registers are word offsets from `BASE_ADDR`: +0 words-written count, +1 start address, +2 transfer length, +3 status. Status bit 0 is done, bit 1 is armed and bit 2 is length-pending. An access whose upper address bits differ from the base's writes nothing and reads zero.
- R3: A length write while the adapter is idle or done arms it in the next cycle. The count reads zero and the first write goes to the start address already loaded. No other trigger exists.
- R4: Each accepted stream word gives exactly one memory write carrying that word. `mem_req`, `mem_addr` and `mem_wdata` hold steady until `mem_ack`.
- R5: `s_ready` is low while a request waits without acknowledge, while not armed, and when the accepted words already equal the length.
- R6: The n-th word of a transfer (from zero) is written at start address + n, wrapping modulo 2^MADDR_W.
- R7: The count register rises by one on each acknowledged write and always reads the number of words written so far.
- R8: Done (status bit 0) is set once the count equals the length; after that no further stream word is accepted or written.
- R9: A length of zero arms the adapter straight into done, with no memory write.
- R10: A length write while a transfer runs sets status bit 2. The running transfer keeps its old length. When it completes, the new length arms a fresh transfer with the count cleared.
- R11: A start-address write during a transfer does not change the addresses of that transfer. It applies only to the next arming.
- R12: Writes to the count register are ignored.
- R13: When `mem_ack` arrives in the first cycle of each request, `s_ready` stays high in that cycle, so one word per cycle is sustained.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| reg_addr | input | RADDR_W | Register access word address |
| reg_wr | input | 1 | Register write strobe |
| reg_wdata | input | RDATA_W | Register write data |
| reg_rdata | output | RDATA_W | Register read data for `reg_addr` (combinational) |
| s_valid | input | 1 | Stream word valid |
| s_data | input | DATA_W | Stream word |
| s_ready | output | 1 | Adapter can take the stream word this cycle |
| mem_req | output | 1 | Memory write request |
| mem_ack | input | 1 | Memory write acknowledge |
| mem_addr | output | MADDR_W | Memory write address |
| mem_wdata | output | DATA_W | Memory write data |

## Verification
The properties assume the memory raises `mem_ack` only in a cycle where `mem_req` is high. They also assume software does not change the start address in the same cycle as a length write. The bench's memory model derives its acknowledge from the sampled request after a programmable latency, including zero. It never acknowledges an idle port. All register traffic goes through single-cycle writes issued one at a time, with the start address written before the length.

// File: rtl/s2m_pkg.sv
`timescale 1ns/1ps
package s2m_pkg;
  // register word offsets from the base address
  typedef enum logic [1:0] {
    OFS_COUNT = 2'd0,
    OFS_START = 2'd1,
    OFS_LEN   = 2'd2,
    OFS_STAT  = 2'd3
  } reg_ofs_e;

  // status register bit positions
  localparam int ST_DONE  = 0;
  localparam int ST_ARMED = 1;
  localparam int ST_PEND  = 2;
  localparam int ST_W     = 3;
endpackage

// File: rtl/s2m_rst_sync.sv
`timescale 1ns/1ps
module s2m_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  generate
    if (STAGES == 1) begin : g_one
      assign sync_d = 1'b1;
    end else begin : g_chain
      assign sync_d = {sync_q[STAGES-2:0], 1'b1};
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= sync_d;
  end

  assign rst_n_sync = sync_q[STAGES-1];
endmodule

// File: rtl/s2m_regs.sv
`timescale 1ns/1ps
module s2m_regs
  import s2m_pkg::*;
#(
  parameter int               RADDR_W   = 16,
  parameter int               RDATA_W   = 32,
  parameter int               MADDR_W   = 16,
  parameter int               LEN_W     = 16,
  parameter logic [RADDR_W-1:0] BASE_ADDR = 16'h5200
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [RADDR_W-1:0] reg_addr,
  input  logic               reg_wr,
  input  logic [RDATA_W-1:0] reg_wdata,
  output logic [RDATA_W-1:0] reg_rdata,
  input  logic               eng_busy,
  input  logic               eng_live,
  input  logic               eng_done,
  input  logic [LEN_W-1:0]   eng_count,
  output logic               arm,
  output logic [LEN_W-1:0]   arm_len,
  output logic [MADDR_W-1:0] arm_addr
);
  localparam int HI_W = RADDR_W - 2;

  logic [MADDR_W-1:0] start_q, start_d;
  logic [LEN_W-1:0]   len_q,   len_d;
  logic               pend_q,  pend_d;
  logic               hit;
  reg_ofs_e           ofs;
  logic               wr_start, wr_len;
  logic [ST_W-1:0]    status;
  logic               unused_wdata;

  assign hit      = (reg_addr[RADDR_W-1:2] == BASE_ADDR[RADDR_W-1:2]);
  assign ofs      = reg_ofs_e'(reg_addr[1:0]);
  assign wr_start = reg_wr && hit && (ofs == OFS_START);
  assign wr_len   = reg_wr && hit && (ofs == OFS_LEN);
  assign unused_wdata = ^reg_wdata;

  // next state
  always_comb begin
    start_d  = start_q;
    len_d    = len_q;
    pend_d   = pend_q;
    arm      = 1'b0;
    arm_len  = len_q;
    arm_addr = start_q;
    if (wr_start) start_d = reg_wdata[MADDR_W-1:0];
    if (wr_len) begin
      len_d = reg_wdata[LEN_W-1:0];
      if (eng_busy) begin
        pend_d = 1'b1;
      end else begin
        arm     = 1'b1;
        arm_len = reg_wdata[LEN_W-1:0];
        pend_d  = 1'b0;
      end
    end else if (pend_q && !eng_busy) begin
      arm    = 1'b1;
      pend_d = 1'b0;
    end
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      start_q <= '0;
      len_q   <= '0;
      pend_q  <= 1'b0;
    end else begin
      if (wr_start)        start_q <= start_d;
      if (wr_len)          len_q   <= len_d;
      if (wr_len || arm)   pend_q  <= pend_d;
    end
  end

  // read path
  always_comb begin
    status           = '0;
    status[ST_DONE]  = eng_done;
    status[ST_ARMED] = eng_live;
    status[ST_PEND]  = pend_q;
    reg_rdata = '0;
    if (hit) begin
      case (ofs)
        OFS_COUNT: reg_rdata = RDATA_W'(eng_count);
        OFS_START: reg_rdata = RDATA_W'(start_q);
        OFS_LEN:   reg_rdata = RDATA_W'(len_q);
        OFS_STAT:  reg_rdata = RDATA_W'(status);
        default:   reg_rdata = '0;
      endcase
    end
  end

  // a base narrower than two bits would leave no room for offsets
  if (HI_W < 1) begin : g_bad_width
    initial $display("s2m_regs: RADDR_W must exceed 2");
  end
endmodule

// File: rtl/s2m_engine.sv
`timescale 1ns/1ps
module s2m_engine #(
  parameter int DATA_W  = 32,
  parameter int MADDR_W = 16,
  parameter int LEN_W   = 16
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               arm,
  input  logic [LEN_W-1:0]   arm_len,
  input  logic [MADDR_W-1:0] arm_addr,
  input  logic               s_valid,
  input  logic [DATA_W-1:0]  s_data,
  output logic               s_ready,
  output logic               mem_req,
  input  logic               mem_ack,
  output logic [MADDR_W-1:0] mem_addr,
  output logic [DATA_W-1:0]  mem_wdata,
  output logic [LEN_W-1:0]   count,
  output logic [LEN_W-1:0]   len,
  output logic               live,
  output logic               done,
  output logic               busy
);
  localparam int CW = LEN_W + 1;

  logic               live_q,  live_d;
  logic [LEN_W-1:0]   len_q,   len_d;
  logic [LEN_W-1:0]   count_q, count_d;
  logic [MADDR_W-1:0] addr_q,  addr_d;
  logic               req_q,   req_d;
  logic [DATA_W-1:0]  wdata_q;
  logic [CW-1:0]      issued;
  logic               room, slot_free, take, ack;
  logic               en_ptr, en_req;

  assign issued    = {1'b0, count_q} + CW'(req_q);
  assign room      = issued < {1'b0, len_q};
  assign slot_free = !req_q || mem_ack;
  assign s_ready   = live_q && room && slot_free;
  assign take      = s_valid && s_ready;
  assign ack       = req_q && mem_ack;

  // next state
  always_comb begin
    live_d  = live_q;
    len_d   = len_q;
    count_d = count_q;
    addr_d  = addr_q;
    req_d   = req_q;
    if (arm) begin
      live_d  = 1'b1;
      len_d   = arm_len;
      count_d = '0;
      addr_d  = arm_addr;
    end else if (ack) begin
      count_d = count_q + 1'b1;
      addr_d  = addr_q + 1'b1;
    end
    if (take)     req_d = 1'b1;
    else if (ack) req_d = 1'b0;
  end

  assign en_ptr = arm || ack;
  assign en_req = take || ack;

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      live_q  <= 1'b0;
      len_q   <= '0;
      count_q <= '0;
      addr_q  <= '0;
      req_q   <= 1'b0;
      wdata_q <= '0;
    end else begin
      if (arm)    live_q  <= live_d;
      if (arm)    len_q   <= len_d;
      if (en_ptr) count_q <= count_d;
      if (en_ptr) addr_q  <= addr_d;
      if (en_req) req_q   <= req_d;
      if (take)   wdata_q <= s_data;
    end
  end

  assign mem_req   = req_q;
  assign mem_addr  = addr_q;
  assign mem_wdata = wdata_q;
  assign count     = count_q;
  assign len       = len_q;
  assign live      = live_q;
  assign done      = live_q && (count_q == len_q);
  assign busy      = live_q && !done;
endmodule

// File: rtl/s2m_write_adapter.sv
`timescale 1ns/1ps
module s2m_write_adapter #(
  parameter int                 DATA_W    = 32,
  parameter int                 MADDR_W   = 16,
  parameter int                 LEN_W     = 16,
  parameter int                 RADDR_W   = 16,
  parameter int                 RDATA_W   = 32,
  parameter logic [RADDR_W-1:0] BASE_ADDR = 16'h5200,
  parameter int                 SYNC_STAGES = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [RADDR_W-1:0] reg_addr,
  input  logic               reg_wr,
  input  logic [RDATA_W-1:0] reg_wdata,
  output logic [RDATA_W-1:0] reg_rdata,
  input  logic               s_valid,
  input  logic [DATA_W-1:0]  s_data,
  output logic               s_ready,
  output logic               mem_req,
  input  logic               mem_ack,
  output logic [MADDR_W-1:0] mem_addr,
  output logic [DATA_W-1:0]  mem_wdata
);
  logic               rst_n_int;
  logic               arm;
  logic [LEN_W-1:0]   arm_len;
  logic [MADDR_W-1:0] arm_addr;
  logic [LEN_W-1:0]   eng_count;
  logic [LEN_W-1:0]   eng_len;
  logic               eng_live, eng_done, eng_busy;

  s2m_rst_sync #(.STAGES(SYNC_STAGES)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_n_sync (rst_n_int)
  );

  s2m_regs #(
    .RADDR_W   (RADDR_W),
    .RDATA_W   (RDATA_W),
    .MADDR_W   (MADDR_W),
    .LEN_W     (LEN_W),
    .BASE_ADDR (BASE_ADDR)
  ) u_regs (
    .clk       (clk),
    .rst_n     (rst_n_int),
    .reg_addr  (reg_addr),
    .reg_wr    (reg_wr),
    .reg_wdata (reg_wdata),
    .reg_rdata (reg_rdata),
    .eng_busy  (eng_busy),
    .eng_live  (eng_live),
    .eng_done  (eng_done),
    .eng_count (eng_count),
    .arm       (arm),
    .arm_len   (arm_len),
    .arm_addr  (arm_addr)
  );

  s2m_engine #(
    .DATA_W  (DATA_W),
    .MADDR_W (MADDR_W),
    .LEN_W   (LEN_W)
  ) u_eng (
    .clk       (clk),
    .rst_n     (rst_n_int),
    .arm       (arm),
    .arm_len   (arm_len),
    .arm_addr  (arm_addr),
    .s_valid   (s_valid),
    .s_data    (s_data),
    .s_ready   (s_ready),
    .mem_req   (mem_req),
    .mem_ack   (mem_ack),
    .mem_addr  (mem_addr),
    .mem_wdata (mem_wdata),
    .count     (eng_count),
    .len       (eng_len),
    .live      (eng_live),
    .done      (eng_done),
    .busy      (eng_busy)
  );
endmodule

// File: rtl/s2m_write_adapter_chk.sv
`timescale 1ns/1ps
module s2m_write_adapter_chk #(
  parameter int DATA_W  = 32,
  parameter int MADDR_W = 16,
  parameter int LEN_W   = 16
) (
  input logic               clk,
  input logic               rst_n,
  input logic               s_valid,
  input logic               s_ready,
  input logic [DATA_W-1:0]  s_data,
  input logic               mem_req,
  input logic               mem_ack,
  input logic [MADDR_W-1:0] mem_addr,
  input logic [DATA_W-1:0]  mem_wdata,
  input logic [LEN_W-1:0]   eng_count,
  input logic [LEN_W-1:0]   eng_len,
  input logic               eng_live,
  input logic               eng_done,
  input logic               arm
);
  a_r5_no_ready_while_waiting: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_ack) |-> !s_ready);

  a_r4_hold_until_ack: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr) && $stable(mem_wdata)));

  a_r4_word_captured: assert property (@(posedge clk) disable iff (!rst_n)
    (s_valid && s_ready) |=> (mem_req && mem_wdata == $past(s_data)));

  a_r7_count_step: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && mem_ack) |=> (eng_count == $past(eng_count) + 1'b1));

  a_r6_addr_step: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && mem_ack) |=> (mem_addr == $past(mem_addr) + 1'b1));

  a_r8_done_refuses: assert property (@(posedge clk) disable iff (!rst_n)
    eng_done |-> !s_ready);

  a_r8_count_bounded: assert property (@(posedge clk) disable iff (!rst_n)
    eng_live |-> (eng_count <= eng_len));

  a_r3_arm_clears: assert property (@(posedge clk) disable iff (!rst_n)
    arm |=> (eng_live && eng_count == '0));
endmodule

bind s2m_write_adapter s2m_write_adapter_chk #(
  .DATA_W  (DATA_W),
  .MADDR_W (MADDR_W),
  .LEN_W   (LEN_W)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .s_valid   (s_valid),
  .s_ready   (s_ready),
  .s_data    (s_data),
  .mem_req   (mem_req),
  .mem_ack   (mem_ack),
  .mem_addr  (mem_addr),
  .mem_wdata (mem_wdata),
  .eng_count (eng_count),
  .eng_len   (eng_len),
  .eng_live  (eng_live),
  .eng_done  (eng_done),
  .arm       (arm)
);

// File: tb/s2m_write_adapter_test.sv
`timescale 1ns/1ps
module s2m_write_adapter_test;
  localparam logic [15:0] BASE = 16'h5200;
  localparam logic [15:0] A_CNT = BASE + 16'd0;
  localparam logic [15:0] A_STA = BASE + 16'd1;
  localparam logic [15:0] A_LEN = BASE + 16'd2;
  localparam logic [15:0] A_ST  = BASE + 16'd3;

  typedef struct packed {
    logic [15:0] start;
    logic [15:0] len;
    logic [3:0]  lat;
    logic [3:0]  gap;
  } vec_t;

  localparam int NV = 4;
  localparam vec_t VECS [NV] = '{
    '{16'h0010, 16'd8, 4'd0, 4'd0},
    '{16'h0040, 16'd5, 4'd2, 4'd1},
    '{16'hFFFE, 16'd4, 4'd1, 4'd0},
    '{16'h0080, 16'd1, 4'd3, 4'd2}
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] reg_addr = '0;
  logic        reg_wr = 1'b0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        s_valid = 1'b0;
  logic [31:0] s_data = '0;
  logic        s_ready;
  logic        mem_req;
  logic        mem_ack = 1'b0;
  logic [15:0] mem_addr;
  logic [31:0] mem_wdata;

  int checks = 0;
  int errors = 0;
  int mem_lat = 0;
  int wait_cnt = 0;
  int wr_total = 0;
  logic [15:0] addr_log [64];
  logic [31:0] data_log [64];

  always #4 clk = ~clk;

  s2m_write_adapter uut (
    .clk(clk), .rst_n(rst_n),
    .reg_addr(reg_addr), .reg_wr(reg_wr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .s_valid(s_valid), .s_data(s_data), .s_ready(s_ready),
    .mem_req(mem_req), .mem_ack(mem_ack), .mem_addr(mem_addr), .mem_wdata(mem_wdata)
  );

  // memory model: acknowledge after mem_lat idle cycles, log every write
  always @(negedge clk) begin
    mem_ack = 1'b0;
    if (rst_n && mem_req) begin
      if (wait_cnt >= mem_lat) begin
        mem_ack = 1'b1;
        addr_log[wr_total % 64] = mem_addr;
        data_log[wr_total % 64] = mem_wdata;
        wr_total = wr_total + 1;
        wait_cnt = 0;
      end else begin
        wait_cnt = wait_cnt + 1;
      end
    end
  end

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic reg_write(input logic [15:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic reg_read(input logic [15:0] a, output logic [31:0] d);
    @(negedge clk);
    reg_addr = a;
    #1 d = reg_rdata;
  endtask

  task automatic send_words(input int n, input int gap, input logic [31:0] seed, output int stalls);
    stalls = 0;
    for (int i = 0; i < n; i++) begin
      for (int g = 0; g < gap; g++) begin
        @(negedge clk);
        s_valid = 1'b0;
      end
      @(negedge clk);
      s_valid = 1'b1;
      s_data  = seed + 32'(i);
      #1;
      while (!s_ready) begin
        stalls++;
        @(negedge clk);
        #1;
      end
    end
    @(negedge clk);
    s_valid = 1'b0;
  endtask

  task automatic wait_done(output logic [31:0] st);
    st = '0;
    for (int k = 0; k < 200; k++) begin
      reg_read(A_ST, st);
      if (st[0]) break;
    end
  endtask

  initial begin
    #(8 * 150000);
    errors++;
    $display("FAIL watchdog actual=%h expected=%h", 32'h0, 32'h1);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [31:0] rd, st;
    int stalls, base_idx;

    // R1: reset state
    s_valid = 1'b1;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    #1;
    check(s_ready == 1'b0, "R1 ready", {31'b0, s_ready}, 32'h0);
    check(mem_req == 1'b0, "R1 req", {31'b0, mem_req}, 32'h0);
    s_valid = 1'b0;
    for (int r = 0; r < 4; r++) begin
      reg_read(BASE + 16'(r), rd);
      check(rd == 32'h0, "R1 register", rd, 32'h0);
    end

    // table-driven transfers
    for (int v = 0; v < NV; v++) begin
      mem_lat = int'(VECS[v].lat);
      base_idx = wr_total;
      reg_write(A_STA, 32'(VECS[v].start));
      reg_write(A_LEN, 32'(VECS[v].len));
      reg_read(A_CNT, rd);
      check(rd == 32'h0, "R3 count cleared on arm", rd, 32'h0);
      reg_read(A_ST, rd);
      check(rd[1] == 1'b1, "R3 armed by length write", rd, 32'h2);
      send_words(int'(VECS[v].len), int'(VECS[v].gap), 32'hA000_0000 | (32'(v) << 16), stalls);
      if (VECS[v].lat == 0 && VECS[v].gap == 0)
        check(stalls == 0, "R13 one word per cycle", 32'(stalls), 32'h0);
      wait_done(st);
      check(st[2:0] == 3'b011, "R8 done status", st, 32'h3);
      reg_read(A_CNT, rd);
      check(rd == 32'(VECS[v].len), "R7 count equals words written", rd, 32'(VECS[v].len));
      check(wr_total - base_idx == int'(VECS[v].len), "R4 one write per word",
            32'(wr_total - base_idx), 32'(VECS[v].len));
      for (int i = 0; i < int'(VECS[v].len); i++) begin
        check(addr_log[(base_idx + i) % 64] == VECS[v].start + 16'(i), "R6 write address",
              32'(addr_log[(base_idx + i) % 64]), 32'(VECS[v].start + 16'(i)));
        check(data_log[(base_idx + i) % 64] == (32'hA000_0000 | (32'(v) << 16)) + 32'(i),
              "R4 write data", data_log[(base_idx + i) % 64],
              (32'hA000_0000 | (32'(v) << 16)) + 32'(i));
      end
    end

    // R8: words offered after done are refused
    base_idx = wr_total;
    s_valid = 1'b1; s_data = 32'hDEAD_0001;
    for (int c = 0; c < 6; c++) begin
      @(negedge clk); #1;
      check(s_ready == 1'b0, "R8 refuse after done", {31'b0, s_ready}, 32'h0);
    end
    s_valid = 1'b0;
    repeat (4) @(negedge clk);
    check(wr_total == base_idx, "R8 no extra write", 32'(wr_total), 32'(base_idx));
    reg_read(A_CNT, rd);
    check(rd == 32'h1, "R8 count unchanged", rd, 32'h1);

    // R12: count register is read-only
    reg_write(A_CNT, 32'h55);
    reg_read(A_CNT, rd);
    check(rd == 32'h1, "R12 count write ignored", rd, 32'h1);

    // R2: register layout and base decode
    reg_read(A_STA, rd);
    check(rd == 32'h0080, "R2 start address readback", rd, 32'h0080);
    reg_read(A_LEN, rd);
    check(rd == 32'h1, "R2 length readback", rd, 32'h1);
    reg_write(BASE + 16'h6, 32'h5);
    reg_read(BASE + 16'h6, rd);
    check(rd == 32'h0, "R2 outside base reads zero", rd, 32'h0);
    reg_read(A_LEN, rd);
    check(rd == 32'h1, "R2 outside write leaves length", rd, 32'h1);
    @(negedge clk); #1;
    check(s_ready == 1'b0, "R2 outside write does not arm", {31'b0, s_ready}, 32'h0);

    // R9: zero length goes straight to done
    base_idx = wr_total;
    reg_write(A_STA, 32'h20);
    reg_write(A_LEN, 32'h0);
    reg_read(A_ST, rd);
    check(rd[2:0] == 3'b011, "R9 zero length done", rd, 32'h3);
    s_valid = 1'b1;
    @(negedge clk); #1;
    check(s_ready == 1'b0, "R9 zero length refuses", {31'b0, s_ready}, 32'h0);
    s_valid = 1'b0;
    repeat (3) @(negedge clk);
    check(wr_total == base_idx, "R9 no write", 32'(wr_total), 32'(base_idx));

    // R10 / R11: reprogram during a transfer
    mem_lat = 1;
    base_idx = wr_total;
    reg_write(A_STA, 32'h0100);
    reg_write(A_LEN, 32'd6);
    send_words(2, 0, 32'hB000_0000, stalls);
    reg_write(A_STA, 32'h0200);
    reg_write(A_LEN, 32'd3);
    reg_read(A_ST, rd);
    check(rd[2:0] == 3'b110, "R10 pending while busy", rd, 32'h6);
    send_words(4, 0, 32'hB000_0002, stalls);
    repeat (6) @(negedge clk);
    for (int i = 0; i < 6; i++)
      check(addr_log[(base_idx + i) % 64] == 16'h0100 + 16'(i), "R11 running addresses kept",
            32'(addr_log[(base_idx + i) % 64]), 32'h0100 + 32'(i));
    reg_read(A_ST, rd);
    check(rd[2:0] == 3'b010, "R10 pending length armed", rd, 32'h2);
    reg_read(A_CNT, rd);
    check(rd == 32'h0, "R10 count cleared", rd, 32'h0);
    send_words(3, 0, 32'hC000_0000, stalls);
    wait_done(st);
    check(st[2:0] == 3'b011, "R10 second transfer done", st, 32'h3);
    reg_read(A_CNT, rd);
    check(rd == 32'h3, "R10 new length used", rd, 32'h3);
    for (int i = 0; i < 3; i++)
      check(addr_log[(base_idx + 6 + i) % 64] == 16'h0200 + 16'(i), "R10 new start used",
            32'(addr_log[(base_idx + 6 + i) % 64]), 32'h0200 + 32'(i));
    check(wr_total - base_idx == 9, "R10 total writes", 32'(wr_total - base_idx), 32'd9);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule